// File: doc/BRIEF.md
# Codec Power-Down Sequencer

This block decides whether a voice codec is powered or in standby, using only the codec's control pin and the activity on its two frame sync inputs. It leaves reset in standby. Two separate conditions return it to standby. The first is a level held high on the shared receive-master-clock / power-down pin. The second is a span with no transmit or receive frame sync pulse that lasts about a millisecond. When the pin is low or carries a clock, the first frame sync pulse on either direction wakes the codec.

The block also controls when the transmit PCM driver may leave high impedance. The driver is held off until the second transmit frame sync pulse after wake-up. The block tells the receive timing whether to run from the pin's own clock, or from the transmit master clock when the pin sits at a fixed level.

All logic runs on one free-running reference clock. Both frame syncs are expected to be synchronous to that clock. The control pin is taken as asynchronous and passes through a synchronizer before the block classifies it.

Top module: `cpd_power_seq`

## Requirements
- R1: While reset is asserted, `power_on`, `tx_drive_permit` and `rx_clk_from_pin` are all 0.
- R2: A pin that has stayed high for QUIET_CYCLES reference clocks forces `power_on` to 0. While the pin stays high, frame sync pulses do not wake the block.
- R3: `rx_clk_from_pin` is 1 while the pin keeps changing, with a change in every window of QUIET_CYCLES clocks. It is 0 once the pin has settled either low or high.
- R4: In standby, with the pin not classified static high, `power_on` becomes 1 on the clock edge that samples a rising edge on `fs_tx` or `fs_rx`. Without such a rising edge it stays 0.
- R5: A rising edge on either frame sync restarts an idle count. If IDLE_LIMIT+1 clock edges pass with no further rising edge, `power_on` drops to 0. A rising edge on the edge where the limit is reached keeps the block on.
- R6: `tx_drive_permit` becomes 1 on the second rising edge of `fs_tx` since wake-up, and a rising edge that itself wakes the block counts as the first. It is 0 whenever `power_on` is 0, and every new wake-up restarts the count.
- R7: Rising edges on `fs_rx` have no effect on the count toward `tx_drive_permit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset |
| mclk_pdn_pin | input | 1 | Shared receive master clock / power-down pin (asynchronous) |
| fs_tx | input | 1 | Transmit frame sync, synchronous to clk |
| fs_rx | input | 1 | Receive frame sync, synchronous to clk |
| power_on | output | 1 | 1 = codec powered, 0 = standby |
| tx_drive_permit | output | 1 | 1 = transmit PCM output may be driven |
| rx_clk_from_pin | output | 1 | 1 = receive timing uses the pin clock, 0 = transmit master clock |

## Verification
The bench builds the block with SYNC_STAGES=2, QUIET_CYCLES=8 and IDLE_LIMIT=50. With those values the idle timeout expires within a few dozen cycles. Random gaps between frame syncs, from 0 to 70 cycles, therefore fall on both sides of the timeout boundary, including the exact edge where a rising frame sync and timeout expiry coincide. The short quiet window lets the bench switch the pin quickly between static low, static high and toggling, and then check the clock-source select and the power-down it forces.

// File: rtl/cpd_pkg.sv
package cpd_pkg;

    // How the shared clock / power-down pin currently behaves
    typedef enum logic [1:0] {
        PIN_QUIET_LO = 2'd0,
        PIN_QUIET_HI = 2'd1,
        PIN_TOGGLING = 2'd2
    } pin_kind_e;

    typedef enum logic {
        PWR_OFF = 1'b0,
        PWR_ON  = 1'b1
    } pwr_state_e;

    // Frame sync rising-edge events of one clock cycle
    typedef struct packed {
        logic tx;
        logic rx;
        logic any;
    } fs_evt_t;

    function automatic logic pin_blocks_power(pin_kind_e k);
        return (k == PIN_QUIET_HI);
    endfunction

    function automatic logic pin_is_clock(pin_kind_e k);
        return (k == PIN_TOGGLING);
    endfunction

endpackage

// File: rtl/cpd_pin_sense.sv
module cpd_pin_sense
    import cpd_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int QUIET_CYCLES = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pin_raw,
    output pin_kind_e kind
);
    localparam int CW = $clog2(QUIET_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(QUIET_CYCLES - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   pin_s;
    logic                   prev_q;
    logic                   change;
    logic [CW-1:0]          quiet_cnt;

    // Synchronizer chain; resets to high so standby is the safe reading
    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
        end else begin
            sync_q[0] <= pin_raw;
            for (int i = 1; i < SYNC_STAGES; i++) begin
                sync_q[i] <= sync_q[i-1];
            end
        end
    end

    assign pin_s  = sync_q[SYNC_STAGES-1];
    assign change = pin_s ^ prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q    <= 1'b1;
            quiet_cnt <= '0;
            kind      <= PIN_QUIET_HI;
        end else begin
            prev_q <= pin_s;
            if (change) begin
                quiet_cnt <= '0;
                kind      <= PIN_TOGGLING;
            end else if (quiet_cnt == LAST) begin
                kind <= pin_s ? PIN_QUIET_HI : PIN_QUIET_LO;
            end else begin
                quiet_cnt <= quiet_cnt + 1'b1;
            end
        end
    end

    AST_EDGE_MEANS_CLOCK: assert property (@(posedge clk) disable iff (rst)
        change |=> (kind == PIN_TOGGLING)); // R3

endmodule

// File: rtl/cpd_fs_watch.sv
module cpd_fs_watch
    import cpd_pkg::*;
#(
    parameter int IDLE_LIMIT = 8000
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    fs_tx,
    input  logic    fs_rx,
    output fs_evt_t evt,
    output logic    idle_expired
);
    localparam int N_FS = 2;
    localparam int CW   = $clog2(IDLE_LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(IDLE_LIMIT);

    logic [N_FS-1:0] fs_in;
    logic [N_FS-1:0] fs_q;
    logic [N_FS-1:0] rise;
    logic [CW-1:0]   idle_cnt;

    assign fs_in = {fs_rx, fs_tx};

    for (genvar g = 0; g < N_FS; g++) begin : g_edge
        always_ff @(posedge clk) begin
            if (rst) fs_q[g] <= 1'b0;
            else     fs_q[g] <= fs_in[g];
        end
        assign rise[g] = fs_in[g] & ~fs_q[g];
    end

    assign evt.tx  = rise[0];
    assign evt.rx  = rise[1];
    assign evt.any = |rise;

    // Counts cycles since the last frame sync edge, saturating at the limit
    always_ff @(posedge clk) begin
        if (rst)                 idle_cnt <= LIM;
        else if (evt.any)        idle_cnt <= '0;
        else if (idle_cnt != LIM) idle_cnt <= idle_cnt + 1'b1;
    end

    assign idle_expired = (idle_cnt == LIM);

    AST_IDLE_RELOAD: assert property (@(posedge clk) disable iff (rst)
        evt.any |=> !idle_expired); // R5

endmodule

// File: rtl/cpd_tx_gate.sv
module cpd_tx_gate (
    input  logic clk,
    input  logic rst,
    input  logic stay_on,
    input  logic fsx_rise,
    output logic permit
);
    logic seen_first;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_first <= 1'b0;
            permit     <= 1'b0;
        end else begin
            seen_first <= stay_on & (seen_first | fsx_rise);
            permit     <= stay_on & (permit | (fsx_rise & seen_first));
        end
    end

    AST_PERMIT_ON_TX_EDGE: assert property (@(posedge clk) disable iff (rst)
        $rose(permit) |-> $past(fsx_rise)); // R6

endmodule

// File: rtl/cpd_power_seq.sv
module cpd_power_seq
    import cpd_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int QUIET_CYCLES = 8,
    parameter int IDLE_LIMIT   = 8000
) (
    input  logic clk,
    input  logic rst,
    input  logic mclk_pdn_pin,
    input  logic fs_tx,
    input  logic fs_rx,
    output logic power_on,
    output logic tx_drive_permit,
    output logic rx_clk_from_pin
);
    pin_kind_e  pin_kind;
    fs_evt_t    evt;
    logic       idle_expired;
    pwr_state_e pwr_q;
    pwr_state_e pwr_d;

    cpd_pin_sense #(
        .SYNC_STAGES (SYNC_STAGES),
        .QUIET_CYCLES(QUIET_CYCLES)
    ) u_pin (
        .clk    (clk),
        .rst    (rst),
        .pin_raw(mclk_pdn_pin),
        .kind   (pin_kind)
    );

    cpd_fs_watch #(
        .IDLE_LIMIT(IDLE_LIMIT)
    ) u_fs (
        .clk         (clk),
        .rst         (rst),
        .fs_tx       (fs_tx),
        .fs_rx       (fs_rx),
        .evt         (evt),
        .idle_expired(idle_expired)
    );

    always_comb begin
        pwr_d = pwr_q;
        unique case (pwr_q)
            PWR_OFF: if (!pin_blocks_power(pin_kind) && evt.any) pwr_d = PWR_ON;
            PWR_ON:  if (pin_blocks_power(pin_kind) || (idle_expired && !evt.any))
                         pwr_d = PWR_OFF;
            default: pwr_d = PWR_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) pwr_q <= PWR_OFF;
        else     pwr_q <= pwr_d;
    end

    cpd_tx_gate u_gate (
        .clk     (clk),
        .rst     (rst),
        .stay_on (pwr_d == PWR_ON),
        .fsx_rise(evt.tx),
        .permit  (tx_drive_permit)
    );

    assign power_on        = (pwr_q == PWR_ON);
    assign rx_clk_from_pin = pin_is_clock(pin_kind);

    AST_RESET_STANDBY: assert property (@(posedge clk)
        rst |=> !power_on); // R1
    AST_PIN_HIGH_DOWN: assert property (@(posedge clk) disable iff (rst)
        pin_blocks_power(pin_kind) |=> !power_on); // R2
    AST_WAKE_NEEDS_FS: assert property (@(posedge clk) disable iff (rst)
        (!power_on && !evt.any) |=> !power_on); // R4
    AST_IDLE_DOWN: assert property (@(posedge clk) disable iff (rst)
        (idle_expired && !evt.any) |=> !power_on); // R5
    AST_PERMIT_NEEDS_POWER: assert property (@(posedge clk) disable iff (rst)
        tx_drive_permit |-> power_on); // R6

endmodule

// File: tb/cpd_power_seq_tb.sv
module cpd_power_seq_tb;
    localparam int IDLE = 50;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pin = 1'b0;
    logic fs_tx = 1'b0;
    logic fs_rx = 1'b0;
    logic pin_tgl = 1'b0;
    logic power_on, tx_drive_permit, rx_clk_from_pin;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    cpd_power_seq #(
        .SYNC_STAGES (2),
        .QUIET_CYCLES(8),
        .IDLE_LIMIT  (IDLE)
    ) u_dut (
        .clk            (clk),
        .rst            (rst),
        .mclk_pdn_pin   (pin),
        .fs_tx          (fs_tx),
        .fs_rx          (fs_rx),
        .power_on       (power_on),
        .tx_drive_permit(tx_drive_permit),
        .rx_clk_from_pin(rx_clk_from_pin)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        if (pin_tgl) pin = ~pin;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    // One-cycle frame sync pulse; returns on the negedge after the sampling edge
    task automatic pulse(input logic x, input logic r);
        tick();
        fs_tx = x;
        fs_rx = r;
        tick();
        fs_tx = 1'b0;
        fs_rx = 1'b0;
    endtask

    // Expected permit state: true once two fs_tx edges seen since wake-up
    function automatic logic exp_permit(input int tx_edges);
        return (tx_edges >= 2);
    endfunction

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int  g;
        int  sel;
        int  txc;
        logic model_up;
        logic lost;
        void'($urandom(1234));

        ticks(5);
        check("R1 power_on in reset", power_on, 1'b0);
        check("R1 permit in reset", tx_drive_permit, 1'b0);
        check("R1 clk sel in reset", rx_clk_from_pin, 1'b0);
        rst = 1'b0;

        // Pin settles low: transmit master clock selected, no wake without fs
        ticks(20);
        check("R3 static low selects tx clock", rx_clk_from_pin, 1'b0);
        check("R4 no wake without fs", power_on, 1'b0);

        pulse(1'b0, 1'b1);
        check("R4 wake on fs_rx edge", power_on, 1'b1);
        check("R6 permit off after rx wake", tx_drive_permit, 1'b0);
        ticks(3);
        pulse(1'b0, 1'b1);
        check("R7 fs_rx does not count", tx_drive_permit, 1'b0);
        ticks(3);
        pulse(1'b1, 1'b0);
        check("R6 first fs_tx keeps permit off", tx_drive_permit, 1'b0);
        ticks(3);
        pulse(1'b1, 1'b0);
        check("R6 second fs_tx grants permit", tx_drive_permit, 1'b1);

        // Idle timeout boundary
        ticks(IDLE);
        check("R5 still on at limit", power_on, 1'b1);
        tick();
        check("R5 off after limit", power_on, 1'b0);
        check("R6 permit off in standby", tx_drive_permit, 1'b0);

        pulse(1'b1, 1'b0);
        check("R4 wake on fs_tx edge", power_on, 1'b1);
        check("R6 count restarts on wake", tx_drive_permit, 1'b0);
        ticks(3);
        pulse(1'b1, 1'b0);
        check("R6 wake edge counted as first", tx_drive_permit, 1'b1);

        // Pin held high forces standby
        pin = 1'b1;
        ticks(20);
        check("R2 pin high forces standby", power_on, 1'b0);
        check("R2 permit dropped", tx_drive_permit, 1'b0);
        check("R3 static high selects tx clock", rx_clk_from_pin, 1'b0);
        pulse(1'b1, 1'b1);
        check("R2 no wake while pin high", power_on, 1'b0);

        // Toggling pin: pin clock selected and wake allowed
        pin_tgl = 1'b1;
        ticks(6);
        check("R3 toggling selects pin clock", rx_clk_from_pin, 1'b1);
        pulse(1'b1, 1'b0);
        check("R4 wake with clocked pin", power_on, 1'b1);
        pin_tgl = 1'b0;
        pin = 1'b0;
        ticks(20);
        check("R3 settled low returns to tx clock", rx_clk_from_pin, 1'b0);

        // Random gaps around the timeout, pin static low
        ticks(IDLE + 10);
        model_up = 1'b0;
        txc = 0;
        for (int it = 0; it < 120; it++) begin
            g   = (it % 10 == 0) ? (IDLE - 1 + (it / 10) % 2) : int'($urandom_range(0, 70));
            sel = int'($urandom_range(1, 3));
            ticks(g);
            check("R5 state before pulse", power_on, model_up && (g <= IDLE));
            lost = !model_up || (g >= IDLE);
            if (lost) txc = 0;
            pulse(sel[0], sel[1]);
            if (sel[0]) txc++;
            model_up = 1'b1;
            check("R4 on after pulse", power_on, 1'b1);
            check(sel[0] ? "R6 permit after pulse" : "R7 permit after rx pulse",
                  tx_drive_permit, exp_permit(txc));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule